// File: doc/BRIEF.md
# Chained-State Byte Scrambler

This block scrambles or unscrambles a stream of short command and reply messages, one byte at a time. Every byte goes through a fixed chain of XOR steps and modulo-256 add and subtract steps. Two 8-bit chaining registers carry state from one byte to the next: one holds the previous plaintext byte and the other holds the previous ciphertext byte. A one-bit direction input picks the direction for each byte. A start-of-message flag that travels with the first byte of a message makes that byte use the seed values in place of the chaining registers.

Bytes enter and leave on valid/ready handshakes. The output is registered, so the result of an accepted byte appears one cycle later. The block keeps one byte of output storage and can accept a new byte in the same cycle that the held byte is taken. Messages are between 1 and 64 bytes long. The block does not frame messages and does not count their length.

Top module: `byte_chain_scrambler`

## Requirements
- R1: While rst_n is low, and in the first cycle after it goes high, out_valid is 0 and in_ready is 1.
- R2: Scrambling (dir=0) computes t = (((x ^ B ^ 0x2b) - 0x05) ^ 0x35) - 0x39 and then y = (((t ^ A ^ 0x5a) - 0xb0) ^ 0x38) - 0x45, with all arithmetic modulo 256. A is the first chaining value and B the second. For the first byte of a message A=0x9b and B=0x54, so input 0x00 gives output 0xda.
- R3: After a scrambled byte, A becomes the input byte and B becomes the output byte.
- R4: Unscrambling (dir=1) computes t = ((((x + 0x45) ^ 0x38) + 0xb0) ^ 0x5a ^ A) and then y = (((t + 0x39) ^ 0x35) + 0x05) ^ 0x2b ^ B. At message start, input 0xda gives output 0x00.
- R5: After an unscrambled byte, A becomes the output byte and B becomes the input byte.
- R6: When in_sof is 1 on an accepted byte, that byte uses A=0x9b and B=0x54, whatever the earlier bytes were.
- R7: A byte accepted in one cycle (in_valid and in_ready both 1) gives out_valid=1 and its result on out_data in the next cycle.
- R8: While out_valid=1 and out_ready=0, out_data stays unchanged, out_valid stays 1 and in_ready is 0.
- R9: A message of up to 64 bytes that is scrambled and then unscrambled, each pass starting with in_sof, comes back unchanged.
- R10: A byte offered while in_ready=0 is not consumed and does not change the chaining state. It is processed exactly once, when it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir | input | 1 | 0 scramble, 1 unscramble; sampled with each accepted byte |
| in_sof | input | 1 | Marks the first byte of a message |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Result byte is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 8 | Result byte |

## Verification
The assertions check the handshake on every cycle: the one-cycle latency, the output holding steady under backpressure, and the output valid flag rising or falling only when a handshake allows it. The byte values themselves can only be shown by the bench's scenarios. These include the known seed vectors in both directions, chains of mixed bytes, reloading the seeds in the middle of a stream, a full 64-byte round trip, and a byte held back by backpressure that must be processed only once.

// File: rtl/byte_chain_scrambler.sv
module byte_chain_scrambler #(
  parameter logic [7:0] SEED_A = 8'h9b,
  parameter logic [7:0] SEED_B = 8'h54
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir,
  input  logic       in_sof,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  logic [7:0] chain_a, chain_b;
  logic [7:0] cur_a, cur_b;
  logic [7:0] s1, s2, u1, u2;
  logic       take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign cur_a    = in_sof ? SEED_A : chain_a;
  assign cur_b    = in_sof ? SEED_B : chain_b;

  always_comb begin
    s1 = (((in_data ^ cur_b ^ 8'h2b) - 8'h05) ^ 8'h35) - 8'h39;
    s2 = (((s1 ^ cur_a ^ 8'h5a) - 8'hb0) ^ 8'h38) - 8'h45;
    u1 = ((((in_data + 8'h45) ^ 8'h38) + 8'hb0) ^ 8'h5a) ^ cur_a;
    u2 = ((((u1 + 8'h39) ^ 8'h35) + 8'h05) ^ 8'h2b) ^ cur_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      chain_a   <= SEED_A;
      chain_b   <= SEED_B;
    end else if (take) begin
      out_valid <= 1'b1;
      if (dir) begin
        out_data <= u2;
        chain_a  <= u2;
        chain_b  <= in_data;
      end else begin
        out_data <= s2;
        chain_a  <= in_data;
        chain_b  <= s2;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_chain_scrambler_chk.sv
module byte_chain_scrambler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!out_valid && in_ready)); // R1
  AST_TAKE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R7
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready)); // R8
endmodule

bind byte_chain_scrambler byte_chain_scrambler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_byte_chain_scrambler.sv
`timescale 1ns/1ps
module sim_byte_chain_scrambler;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dir = 1'b0, in_sof = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid;
  logic [7:0] out_data;
  int errors = 0, checks = 0;
  logic [7:0] ma = 8'h9b, mb = 8'h54;
  logic [7:0] plain [64];
  logic [7:0] ciph [64];

  always #4 clk = ~clk;

  byte_chain_scrambler u0 (
    .clk(clk), .rst_n(rst_n), .dir(dir), .in_sof(in_sof), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  localparam logic [9:0] VEC [16] = '{
    {1'b0,1'b1,8'h00}, {1'b0,1'b0,8'h11}, {1'b0,1'b0,8'hff}, {1'b0,1'b0,8'h80},
    {1'b1,1'b1,8'hda}, {1'b1,1'b0,8'h3c}, {1'b1,1'b0,8'h00}, {1'b1,1'b0,8'hff},
    {1'b0,1'b1,8'h5a}, {1'b0,1'b0,8'h5a}, {1'b1,1'b0,8'h7e}, {1'b0,1'b0,8'h01},
    {1'b1,1'b1,8'h42}, {1'b0,1'b0,8'h42}, {1'b0,1'b1,8'hc3}, {1'b1,1'b0,8'h99}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic d, input logic s, input logic [7:0] x);
    logic [7:0] a, b, t, y;
    a = s ? 8'h9b : ma;
    b = s ? 8'h54 : mb;
    if (!d) begin
      t = (((x ^ b ^ 8'h2b) - 8'h05) ^ 8'h35) - 8'h39;
      y = (((t ^ a ^ 8'h5a) - 8'hb0) ^ 8'h38) - 8'h45;
      ma = x; mb = y;
    end else begin
      t = ((((x + 8'h45) ^ 8'h38) + 8'hb0) ^ 8'h5a) ^ a;
      y = ((((t + 8'h39) ^ 8'h35) + 8'h05) ^ 8'h2b) ^ b;
      ma = y; mb = x;
    end
    return y;
  endfunction

  task automatic send(input logic d, input logic s, input logic [7:0] x, output logic [7:0] got);
    @(negedge clk);
    dir = d; in_sof = s; in_data = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    check("R7 out_valid", {7'd0, out_valid}, 8'd1);
    got = out_data;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got, exp, held;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {7'd0, out_valid}, 8'd0);
    check("R1 in_ready in reset", {7'd0, in_ready}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {7'd0, out_valid}, 8'd0);

    send(1'b0, 1'b1, 8'h00, got);
    check("R2 seed vector", got, 8'hda);
    send(1'b1, 1'b1, 8'hda, got);
    check("R4 seed vector", got, 8'h00);

    for (int i = 0; i < 16; i++) begin
      exp = model(VEC[i][9], VEC[i][8], VEC[i][7:0]);
      send(VEC[i][9], VEC[i][8], VEC[i][7:0], got);
      check(VEC[i][8] ? "R6 sof reload" : (VEC[i][9] ? "R5 R4 chain" : "R3 R2 chain"), got, exp);
    end

    send(1'b0, 1'b0, 8'h77, got);
    exp = model(1'b0, 1'b0, 8'h77);
    check("R3 chain after table", got, exp);
    send(1'b0, 1'b1, 8'h00, got);
    ma = 8'h00; mb = 8'hda;
    check("R6 mid-stream reload", got, 8'hda);

    @(negedge clk);
    out_ready = 1'b0;
    dir = 1'b0; in_sof = 1'b0; in_data = 8'h21; in_valid = 1'b1;
    exp = model(1'b0, 1'b0, 8'h21);
    @(negedge clk);
    in_data = 8'h34;
    held = out_data;
    check("R8 held value", held, exp);
    repeat (3) begin
      @(negedge clk);
      check("R8 in_ready low", {7'd0, in_ready}, 8'd0);
      check("R8 out_data stable", out_data, held);
    end
    exp = model(1'b0, 1'b0, 8'h34);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 stalled byte once", out_data, exp);
    send(1'b0, 1'b0, 8'h55, got);
    exp = model(1'b0, 1'b0, 8'h55);
    check("R10 chain after stall", got, exp);

    for (int i = 0; i < 64; i++) begin
      plain[i] = 8'(i * 37 + 11);
      send(1'b0, i == 0, plain[i], got);
      ciph[i] = got;
    end
    for (int i = 0; i < 64; i++) begin
      send(1'b1, i == 0, ciph[i], got);
      check("R9 round trip", got, plain[i]);
    end

    @(negedge clk);
    check("R7 idle after drain", {7'd0, out_valid}, 8'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule